// File: doc/BRIEF.md
# Serial Boot Image Loader

This block sits after reset between a byte-wide serial receiver and the on-chip program RAM. It reads a short text header that gives the image size in bytes as decimal digits, ended by a single space (0x20). It then copies exactly that many raw bytes into RAM, with the first byte at address zero and each later byte at the next address. The link is expected to run at 115200 bit/s, so a byte arrives only every few thousand clock cycles. The block still accepts a new byte on every cycle, which lets a faster link or a bench drive it back to back.

When the final byte has been written, the loader raises a completion flag. That flag keeps the processor out of reset until it is set, and it stays set until the next reset. A malformed header raises an error flag, and the loader goes back to waiting for a fresh header. The RAM port is one byte lane of a 32-bit word: the received byte is copied onto all four lanes, and a one-hot lane enable chooses which lane is stored.

Top module: `uart_image_loader`

## Requirements
- R1: After reset, `mem_we`, `load_done` and `load_error` are 0 and the block waits for a header.
- R2: Header digits 0x30..0x39 build the length in decimal, most significant digit first. Leading zeros are allowed, so "007 " loads 7 bytes.
- R3: A header byte that is neither a digit nor 0x20 sets `load_error` in the next cycle and clears the partly parsed length. Parsing then restarts with the next byte.
- R4: A space that ends a length of 0 (including an empty header) or a length above 65536 sets `load_error` in the next cycle. No RAM write follows, and header parsing restarts.
- R5: Each payload byte accepted with `rx_valid` produces exactly one cycle with `mem_we` high, in the cycle after the strobe.
- R6: Payload byte n (counting from 0) is written with `mem_addr` = n and `mem_be` = 1 << (n mod 4), and `mem_wdata` holds the byte in every lane. A 65536-byte image ends at address 65535.
- R7: `load_done` rises in the cycle after the final write and stays high until reset.
- R8: After `load_done` is set, received bytes cause no write and do not change `load_done`.
- R9: `load_error` stays high until the next byte is received in the header phase, and it then takes that byte's verdict.
- R10: The value on `rx_data` is ignored while `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_be | output | 4 | One-hot byte lane enable |
| mem_wdata | output | 32 | Write data, the byte copied to all lanes |
| load_done | output | 1 | Image complete; the core may leave reset |
| load_error | output | 1 | The last header was rejected |

## Verification
The main function is tried with several patterns. A short image sent after a header that failed on a bad character shows that the accumulator really clears. A zero-padded length whose payload contains space and digit bytes shows that the payload is never parsed as header text. Spaced strobes with junk on the data lines show that idle cycles are ignored. A full 65536-byte image sent back to back checks the top boundary of the length range and the last address. Empty, zero, 65537 and nine-digit headers cover the two rejection paths, and bytes sent after completion show that the loader stays closed.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_NINE  = 8'h39;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_LOAD = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    typedef struct packed {
        logic       is_digit;
        logic       is_space;
        logic [3:0] value;
    } hdr_class_t;

    function automatic hdr_class_t classify(input logic [7:0] b);
        hdr_class_t c;
        c.is_digit = (b >= CH_ZERO) && (b <= CH_NINE);
        c.is_space = (b == CH_SPACE);
        c.value    = c.is_digit ? b[3:0] : 4'd0;
        return c;
    endfunction

endpackage

// File: rtl/ldr_hdr_parser.sv
module ldr_hdr_parser
    import ldr_pkg::*;
#(
    parameter int LEN_W   = 17,
    parameter int MAX_LEN = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    output logic             good_o,
    output logic             bad_o,
    output logic [LEN_W-1:0] len_o
);
    localparam int ACC_W = LEN_W + 4;

    hdr_class_t       cls;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_nxt;
    logic             ovf;

    assign cls     = classify(byte_i);
    assign acc_nxt = acc * ACC_W'(10) + ACC_W'(cls.value);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (take_i) begin
            if (cls.is_digit) begin
                if (!ovf) begin
                    if (acc_nxt > ACC_W'(MAX_LEN)) ovf <= 1'b1;
                    else                          acc <= acc_nxt;
                end
            end else begin
                acc <= '0;
                ovf <= 1'b0;
            end
        end
    end

    assign good_o = take_i && cls.is_space && !ovf && (acc != '0);
    assign bad_o  = take_i && !cls.is_digit && !good_o;
    assign len_o  = acc[LEN_W-1:0];

    a_r4_acc_bounded: assert property (@(posedge clk) disable iff (rst)
        !ovf |-> acc <= ACC_W'(MAX_LEN));

    a_r4_good_nonzero: assert property (@(posedge clk) disable iff (rst)
        good_o |-> len_o != '0);

endmodule

// File: rtl/ldr_payload_writer.sv
module ldr_payload_writer #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 4,
    parameter int LEN_W  = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               take_i,
    input  logic [7:0]         byte_i,
    output logic               last_o,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [8*LANES-1:0] mem_wdata
);
    localparam int LANE_W = $clog2(LANES);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic [LANES-1:0] lane_hit;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_hit[g] = (cnt[LANE_W-1:0] == LANE_W'(g));
        end
    endgenerate

    assign last_o = take_i && (cnt == len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            len       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (start_i) begin
                cnt <= '0;
                len <= len_i;
            end else if (take_i) begin
                mem_we    <= 1'b1;
                mem_addr  <= cnt[ADDR_W-1:0];
                mem_be    <= lane_hit;
                mem_wdata <= {LANES{byte_i}};
                cnt       <= cnt + LEN_W'(1);
            end
        end
    end

    a_r6_one_lane: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $countones(mem_be) == 1);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

endmodule

// File: rtl/uart_image_loader.sv
module uart_image_loader
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [8*LANES-1:0] mem_wdata,
    output logic               load_done,
    output logic               load_error
);
    localparam int MAX_LEN = 1 << ADDR_W;
    localparam int LEN_W   = ADDR_W + 1;

    phase_t           ph;
    logic             hdr_take;
    logic             pay_take;
    logic             hdr_good;
    logic             hdr_bad;
    logic             pay_last;
    logic [LEN_W-1:0] hdr_len;

    assign hdr_take = rx_valid && (ph == PH_HDR);
    assign pay_take = rx_valid && (ph == PH_LOAD);

    ldr_hdr_parser #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) i_parser (
        .clk    (clk),
        .rst    (rst),
        .take_i (hdr_take),
        .byte_i (rx_data),
        .good_o (hdr_good),
        .bad_o  (hdr_bad),
        .len_o  (hdr_len)
    );

    ldr_payload_writer #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LEN_W  (LEN_W)
    ) i_writer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (hdr_good),
        .len_i     (hdr_len),
        .take_i    (pay_take),
        .byte_i    (rx_data),
        .last_o    (pay_last),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_HDR;
            load_done  <= 1'b0;
            load_error <= 1'b0;
        end else begin
            load_done <= (ph == PH_DONE);
            if (hdr_take) load_error <= hdr_bad;
            case (ph)
                PH_HDR:  if (hdr_good) ph <= PH_LOAD;
                PH_LOAD: if (pay_last) ph <= PH_DONE;
                default: ph <= PH_DONE;
            endcase
        end
    end

    a_r5_write_only_loading: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ph != PH_HDR);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        load_done |=> load_done);

    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        load_done |-> !mem_we);

    a_r3_error_no_write: assert property (@(posedge clk) disable iff (rst)
        load_error |-> !mem_we);

endmodule

// File: tb/test_uart_image_loader.sv
module test_uart_image_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        load_done;
    logic        load_error;

    int checks = 0;
    int failures = 0;
    int writes = 0;
    int last_addr = -1;

    always #10 clk = ~clk;

    uart_image_loader i_uart_image_loader (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .load_done  (load_done),
        .load_error (load_error)
    );

    // behavioural reference model
    int          m_ph;
    int          m_acc;
    bit          m_big;
    int          m_cnt;
    int          m_len;
    logic        e_we;
    logic [15:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_data;
    logic        e_done;
    logic        e_err;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_acc = 0; m_big = 0; m_cnt = 0; m_len = 0;
            e_we = 0; e_addr = 0; e_be = 0; e_data = 0; e_done = 0; e_err = 0;
        end else begin
            if (m_ph == 2) e_done = 1;
            e_we = 0;
            if (rx_valid) begin
                if (m_ph == 0) begin
                    e_err = 0;
                    if (rx_data >= 8'h30 && rx_data <= 8'h39) begin
                        if (!m_big) begin
                            m_acc = m_acc * 10 + int'(rx_data) - 48;
                            if (m_acc > 65536) m_big = 1;
                        end
                    end else if (rx_data == 8'h20) begin
                        if (m_acc == 0 || m_big) e_err = 1;
                        else begin m_len = m_acc; m_cnt = 0; m_ph = 1; end
                        m_acc = 0; m_big = 0;
                    end else begin
                        e_err = 1; m_acc = 0; m_big = 0;
                    end
                end else if (m_ph == 1) begin
                    e_we = 1;
                    e_addr = m_cnt[15:0];
                    e_be = 4'b0001 << (m_cnt % 4);
                    e_data = {4{rx_data}};
                    m_cnt++;
                    if (m_cnt == m_len) m_ph = 2;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle; outputs only move at posedge
    always @(negedge clk) begin
        if (!rst && $time > 60) begin
            check(mem_we === e_we, "R5 mem_we", mem_we, e_we);
            if (e_we) begin
                check(mem_addr === e_addr, "R6 mem_addr", mem_addr, e_addr);
                check(mem_be === e_be, "R6 mem_be", mem_be, e_be);
                check(mem_wdata === e_data, "R6 mem_wdata", mem_wdata, e_data);
            end
            check(load_done === e_done, "R7 load_done", load_done, e_done);
            check(load_error === e_err, "R9 load_error", load_error, e_err);
            if (mem_we === 1'b1) begin
                writes++;
                last_addr = int'(mem_addr);
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        writes = 0;
        last_addr = -1;
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data = b;
        if (gap > 0) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_data = 8'h41; // R10: junk while strobe low
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic send_str(input string s, input int gap);
        for (int i = 0; i < s.len(); i++) send(s[i], gap);
    endtask

    task automatic settle();
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(mem_we === 1'b0, "R1 mem_we after reset", mem_we, 0);
        check(load_done === 1'b0, "R1 load_done after reset", load_done, 0);
        check(load_error === 1'b0, "R1 load_error after reset", load_error, 0);

        // R3: bad character, then R9 clearing, then a short image
        send_str("1x", 1);
        settle();
        check(load_error === 1'b1, "R3 error on bad char", load_error, 1);
        send("3", 2);
        settle();
        check(load_error === 1'b0, "R9 error cleared by next byte", load_error, 0);
        send(" ", 1);
        send(8'hC3, 0); send(8'h20, 0); send(8'h07, 0);
        settle();
        check(writes == 3, "R2 three writes after restart", writes, 3);
        check(load_done === 1'b1, "R7 done after image", load_done, 1);
        // R8: later bytes ignored
        send_str("12 ", 0);
        send(8'hFF, 1);
        settle();
        check(writes == 3, "R8 no writes after done", writes, 3);
        check(load_done === 1'b1, "R8 done stays", load_done, 1);

        // R4 rejections
        do_reset();
        send_str("0 ", 1); settle();
        check(load_error === 1'b1, "R4 zero length", load_error, 1);
        send_str(" ", 1); settle();
        check(load_error === 1'b1, "R4 empty header", load_error, 1);
        send_str("65537 ", 0); settle();
        check(load_error === 1'b1, "R4 length 65537", load_error, 1);
        send_str("123456789 ", 2); settle();
        check(load_error === 1'b1, "R4 nine digit length", load_error, 1);
        check(writes == 0, "R4 no writes on rejection", writes, 0);

        // R2 leading zeros, payload holding space/digit bytes, R10 gaps
        send_str("007 ", 3);
        send(8'h20, 2); send(8'h35, 0); send(8'h78, 4); send(8'h20, 1);
        send(8'h00, 0); send(8'h39, 5); send(8'hAA, 1);
        settle();
        check(writes == 7, "R2 leading zero length", writes, 7);
        check(load_done === 1'b1, "R7 done after padded header", load_done, 1);
        check(load_error === 1'b0, "R9 error clear after load", load_error, 0);

        // R6 full size image
        do_reset();
        send_str("65536 ", 0);
        for (int n = 0; n < 65536; n++) send(n[7:0] ^ 8'h5A, 0);
        settle();
        check(writes == 65536, "R6 full image write count", writes, 65536);
        check(last_addr == 65535, "R6 last address", last_addr, 65535);
        check(load_done === 1'b1, "R7 done after full image", load_done, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule